// File: doc/BRIEF.md
# CAN Physical-Layer Control Register Slice

This block is one slot of a serial command register map. It holds the settings of a CAN bus transceiver: whether the secondary supply stays up when the bus is off-line, a listen-only partial-networking enable, the off-line timeout length, transmitter disable, loopback, active-mode enable, and split-pin drive. It also holds five reserved bits. A 16-bit command word arrives with a valid strobe. The two top bits address the register map, and this slice answers only to address 2'b11.

Every access that hits the slice returns a word on the cycle after the command. Bit 13 of the command picks that word. It is either the slice's own feedback image or a general-purpose status word supplied from outside. Bit 12 decides whether the low twelve command bits are also written into the control fields. Two external mode events, entering on-line mode and entering active mode, clear the listen enable in hardware. The clear wins over a simultaneous software write.

Top module: `phy_ctl_slice`

## Requirements
- R1: In reset and on the first cycle after it, every control field reads 0, the reserved field `ctl_rsvd` reads 5'b00010, and `rd_valid` is 0.
- R2: A valid command whose bits 15:14 differ from 2'b11 leaves all control fields unchanged. On the next cycle it gives `rd_valid` = 0 and `rd_data` = 0.
- R3: A command with bits 15:14 = 2'b11 and bit 12 = 1 returns a word but leaves every control field unchanged.
- R4: A command with bits 15:14 = 2'b11 and bit 12 = 0 loads its bits 11:0 on the next cycle, in this layout: 11 supply-keep, 10 listen enable, 9 long timeout, 8 transmitter off, 7 loopback, 6 active enable, 5 split enable, 4:0 reserved.
- R5: A hitting command with bit 13 = 0 gives, on the next cycle, `rd_valid` = 1 and `rd_data` = {2'b11, bit 13, bit 12, the control fields as held before this command's write}, with the fields in the R4 layout.
- R6: A hitting command with bit 13 = 1 gives, on the next cycle, `rd_valid` = 1 and `rd_data` equal to `gp_fb_word` as sampled in the command cycle.
- R7: When `evt_online` or `evt_active` is high, the listen enable reads 0 on the next cycle. The other fields do not change.
- R8: When a write and a mode event fall in the same cycle, the listen enable ends at 0. Every other field takes the written value.
- R9: `ctl_loopback_eff` is 1 only when both loopback and transmitter-off are held at 1.
- R10: A cycle with `cmd_valid` = 0 changes no control field (apart from R7) and gives `rd_valid` = 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 16 | Address, access bits and control data |
| gp_fb_word | input | 16 | General-purpose status word returned when bit 13 is set |
| evt_online | input | 1 | Transceiver entered on-line mode |
| evt_active | input | 1 | Transceiver entered active mode |
| rd_valid | output | 1 | Response word valid (cycle after a hit) |
| rd_data | output | 16 | Response word, zero when not valid |
| ctl_supply_keep | output | 1 | Keep secondary supply in off-line mode |
| ctl_listen_en | output | 1 | Partial-networking listen enable |
| ctl_long_tmo | output | 1 | Long off-line timeout select |
| ctl_tx_off | output | 1 | Transmitter disabled |
| ctl_loopback | output | 1 | Loopback requested |
| ctl_active_en | output | 1 | Active mode enable |
| ctl_split_en | output | 1 | Split pin enabled |
| ctl_rsvd | output | 5 | Reserved field |
| ctl_loopback_eff | output | 1 | Loopback in force (needs transmitter off) |

## Verification
A software write that sets the listen enable and a hardware mode event that clears it can land on the same clock edge. The bench makes this happen by raising `evt_online` or `evt_active` during a write command whose bit 10 is 1. The check is that the listen bit reads 0 one cycle later while the other written fields take effect. A scrambled stream of command words and events, running against a behavioural reference model, creates further collisions. These include read-only commands and misaddressed commands combined with events.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int CTL_W    = 12;
    localparam int RSVD_W   = 5;
    localparam int ADDR_LSB = WORD_W - ADDR_W;
    localparam int SRC_BIT  = ADDR_LSB - 1;
    localparam int RO_BIT   = ADDR_LSB - 2;

    typedef struct packed {
        logic              supply_keep;
        logic              listen_en;
        logic              long_tmo;
        logic              tx_off;
        logic              loopback;
        logic              active_en;
        logic              split_en;
        logic [RSVD_W-1:0] rsvd;
    } ctl_fields_t;

    localparam ctl_fields_t CTL_RESET = '{
        supply_keep: 1'b0, listen_en: 1'b0, long_tmo: 1'b0, tx_off: 1'b0,
        loopback: 1'b0, active_en: 1'b0, split_en: 1'b0, rsvd: 5'b00010
    };

    typedef enum logic {
        SRC_SELF = 1'b0,
        SRC_GP   = 1'b1
    } rd_src_e;

    typedef struct packed {
        logic        hit;
        logic        wr;
        logic        ro;
        rd_src_e     src;
        ctl_fields_t data;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(
        input logic              valid,
        input logic [WORD_W-1:0] w,
        input logic [ADDR_W-1:0] own_addr
    );
        cmd_dec_t d;
        d.hit  = valid && (w[WORD_W-1:ADDR_LSB] == own_addr);
        d.ro   = w[RO_BIT];
        d.src  = rd_src_e'(w[SRC_BIT]);
        d.wr   = d.hit && !d.ro;
        d.data = ctl_fields_t'(w[CTL_W-1:0]);
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] self_image(
        input logic [ADDR_W-1:0] own_addr,
        input rd_src_e           src,
        input logic              ro,
        input ctl_fields_t       s
    );
        return {own_addr, logic'(src), ro, s};
    endfunction

endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
    import phy_ctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 2'b11
) (
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output cmd_dec_t          dec
);
    always_comb begin
        dec = decode_cmd(cmd_valid, cmd_word, OWN_ADDR);
    end
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
    import phy_ctl_pkg::*;
#(
    parameter int N_EVT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             ro,
    input  logic             wr,
    input  ctl_fields_t      wdata,
    input  logic [N_EVT-1:0] evt,
    output ctl_fields_t      state
);
    logic        clr_listen;
    ctl_fields_t nxt;

    always_comb begin
        clr_listen = |evt;
    end

    always_comb begin
        nxt = state;
        if (wr) nxt = wdata;
        if (clr_listen) nxt.listen_en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CTL_RESET;
        else     state <= nxt;
    end

    AST_EVT_CLEARS_LISTEN: assert property (@(posedge clk) disable iff (rst)
        clr_listen |=> !state.listen_en); // R7
    AST_RO_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (hit && ro && !clr_listen) |=> $stable(state)); // R3
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr_listen) |=> (state == $past(wdata))); // R4
    AST_COLLIDE_OTHERS: assert property (@(posedge clk) disable iff (rst)
        (wr && clr_listen) |=> (state.supply_keep == $past(wdata.supply_keep)
                                && state.rsvd == $past(wdata.rsvd))); // R8
endmodule

// File: rtl/phy_rdback_mux.sv
module phy_rdback_mux
    import phy_ctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 2'b11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              ro,
    input  rd_src_e           src,
    input  ctl_fields_t       state,
    input  logic [WORD_W-1:0] gp_fb,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] sel_word;

    always_comb begin
        unique case (src)
            SRC_GP:   sel_word = gp_fb;
            default:  sel_word = self_image(OWN_ADDR, src, ro, state);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= hit;
            rd_data  <= hit ? sel_word : '0;
        end
    end

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (!rd_valid && rd_data == '0)); // R2
    AST_GP_RETURN: assert property (@(posedge clk) disable iff (rst)
        (hit && src == SRC_GP) |=> (rd_valid && rd_data == $past(gp_fb))); // R6
endmodule

// File: rtl/phy_ctl_slice.sv
module phy_ctl_slice
    import phy_ctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 2'b11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [15:0]       cmd_word,
    input  logic [15:0]       gp_fb_word,
    input  logic              evt_online,
    input  logic              evt_active,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              ctl_supply_keep,
    output logic              ctl_listen_en,
    output logic              ctl_long_tmo,
    output logic              ctl_tx_off,
    output logic              ctl_loopback,
    output logic              ctl_active_en,
    output logic              ctl_split_en,
    output logic [4:0]        ctl_rsvd,
    output logic              ctl_loopback_eff
);
    cmd_dec_t    dec;
    ctl_fields_t state;

    phy_cmd_decode #(.OWN_ADDR(OWN_ADDR)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .dec       (dec)
    );

    phy_ctl_regs #(.N_EVT(2)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .hit   (dec.hit),
        .ro    (dec.ro),
        .wr    (dec.wr),
        .wdata (dec.data),
        .evt   ({evt_active, evt_online}),
        .state (state)
    );

    phy_rdback_mux #(.OWN_ADDR(OWN_ADDR)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .hit      (dec.hit),
        .ro       (dec.ro),
        .src      (dec.src),
        .state    (state),
        .gp_fb    (gp_fb_word),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always_comb begin
        ctl_supply_keep  = state.supply_keep;
        ctl_listen_en    = state.listen_en;
        ctl_long_tmo     = state.long_tmo;
        ctl_tx_off       = state.tx_off;
        ctl_loopback     = state.loopback;
        ctl_active_en    = state.active_en;
        ctl_split_en     = state.split_en;
        ctl_rsvd         = state.rsvd;
        ctl_loopback_eff = state.loopback && state.tx_off;
    end

    AST_IDLE_NO_REPLY: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rd_valid); // R10
endmodule

// File: tb/test_phy_ctl_slice.sv
`timescale 1ns/1ps
module test_phy_ctl_slice;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [15:0] gp_fb_word = '0;
    logic        evt_online = 1'b0;
    logic        evt_active = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        c_keep, c_listen, c_tmo, c_txoff, c_lb, c_act, c_split, c_lbe;
    logic [4:0]  c_rsvd;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    phy_ctl_slice i_phy_ctl_slice (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .gp_fb_word(gp_fb_word), .evt_online(evt_online), .evt_active(evt_active),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ctl_supply_keep(c_keep), .ctl_listen_en(c_listen), .ctl_long_tmo(c_tmo),
        .ctl_tx_off(c_txoff), .ctl_loopback(c_lb), .ctl_active_en(c_act),
        .ctl_split_en(c_split), .ctl_rsvd(c_rsvd), .ctl_loopback_eff(c_lbe)
    );

    // reference model
    logic [11:0] m_state = 12'h002;
    logic        m_rv    = 1'b0;
    logic [15:0] m_rd    = '0;
    string       st_tag  = "R1";
    string       rd_tag  = "R1";

    always @(posedge clk) begin
        if (rst) begin
            m_state = 12'h002; m_rv = 1'b0; m_rd = '0;
            st_tag = "R1"; rd_tag = "R1";
        end else begin
            if (cmd_valid && cmd_word[15:14] == 2'b11) begin
                m_rv = 1'b1;
                m_rd = cmd_word[13] ? gp_fb_word
                                    : {2'b11, cmd_word[13], cmd_word[12], m_state};
                rd_tag = cmd_word[13] ? "R6" : "R5";
                if (!cmd_word[12]) begin
                    m_state = cmd_word[11:0];
                    st_tag = "R4";
                end else st_tag = "R3";
            end else begin
                m_rv = 1'b0; m_rd = '0;
                rd_tag = cmd_valid ? "R2" : "R10";
                st_tag = cmd_valid ? "R2" : "R10";
            end
            if (evt_online || evt_active) begin
                m_state[10] = 1'b0;
                st_tag = (st_tag == "R4") ? "R8" : "R7";
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [11:0] got;
            got = {c_keep, c_listen, c_tmo, c_txoff, c_lb, c_act, c_split, c_rsvd};
            check(got == m_state, st_tag, 32'(got), 32'(m_state));
            check(rd_valid == m_rv && rd_data == m_rd, rd_tag,
                  {15'd0, rd_valid, rd_data}, {15'd0, m_rv, m_rd});
            check(c_lbe == (m_state[7] && m_state[8]), "R9",
                  32'(c_lbe), 32'(m_state[7] && m_state[8]));
        end
    end

    task automatic op(input logic v, input logic [15:0] w, input logic [15:0] gp,
                      input logic on, input logic ac);
        @(negedge clk);
        cmd_valid = v; cmd_word = w; gp_fb_word = gp;
        evt_online = on; evt_active = ac;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_word = '0; evt_online = 1'b0; evt_active = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 explicit: read defaults, read-only, own image
        op(1'b1, 16'hD000, 16'h1234, 1'b0, 1'b0);
        #1 check(rd_data == 16'hD002, "R1", 32'(rd_data), 32'h0000D002);
        // R4 write all fields, R5 then read back
        op(1'b1, 16'hCFE1, 16'h0, 1'b0, 1'b0);
        op(1'b1, 16'hD000, 16'h0, 1'b0, 1'b0);
        #1 check(rd_data == 16'hDFE1, "R5", 32'(rd_data), 32'h0000DFE1);
        // R6 general-purpose return, read-only
        op(1'b1, 16'hF000, 16'hA5C3, 1'b0, 1'b0);
        #1 check(rd_data == 16'hA5C3, "R6", 32'(rd_data), 32'h0000A5C3);
        // R2 misaddressed write
        op(1'b1, 16'h8000, 16'h0, 1'b0, 1'b0);
        #1 check(c_keep == 1'b1 && !rd_valid, "R2", {31'd0, c_keep}, 32'd1);
        // R7 event clears listen
        op(1'b0, 16'h0, 16'h0, 1'b1, 1'b0);
        #1 check(c_listen == 1'b0 && c_keep, "R7", 32'(c_listen), 32'd0);
        // R8 collision: write listen=1 with active event
        op(1'b1, 16'hC581, 16'h0, 1'b0, 1'b1);
        #1 check(c_listen == 1'b0 && c_txoff && c_lb, "R8", 32'(c_listen), 32'd0);
        // R9 loopback gated by tx_off
        op(1'b1, 16'hC080, 16'h0, 1'b0, 1'b0);
        #1 check(c_lbe == 1'b0, "R9", 32'(c_lbe), 32'd0);
        // R3 read-only with data bits set
        op(1'b1, 16'hDFFF, 16'h0, 1'b0, 1'b0);
        #1 check(c_keep == 1'b0 && c_lb, "R3", 32'(c_keep), 32'd0);
        // scrambled stream
        begin
            logic [31:0] lfsr = 32'hACE1_2345;
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                @(negedge clk);
                cmd_valid  = lfsr[3] | lfsr[9];
                cmd_word   = lfsr[31:16] ^ {lfsr[7:0], lfsr[15:8]};
                if (lfsr[12]) cmd_word[15:14] = 2'b11;
                gp_fb_word = lfsr[15:0];
                evt_online = lfsr[5] & lfsr[11];
                evt_active = lfsr[6] & lfsr[13] & lfsr[2];
            end
            @(negedge clk);
            cmd_valid = 1'b0; evt_online = 1'b0; evt_active = 1'b0;
            repeat (2) @(negedge clk);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule